// File: doc/BRIEF.md
# Timer with Shared Assignable Prescaler

This block is a free-running up-counter with a configuration byte and one shared prescaler. The count source is either the internal instruction-cycle enable or edges seen on an external clock pin. The pin is brought into the system clock domain and its rising or falling edge is chosen by a configuration bit. The single prescaler is routed by one ownership bit. Either it divides the timer's count events, or it divides instruction-cycle ticks into a watchdog tick pulse for a watchdog counter that lives outside the block. The rate code gives powers of two, and the timer path's ratios are one power of two above the watchdog path's ratios for the same code.

Software sees three registers on a simple write port and a combinational read port. These are the timer value, the configuration byte, and a control byte with the overflow flag and its interrupt enable. Loading the timer resets the prescaler and stalls counting briefly, so that a reload can be made without losing sync to the count source. Any change to the routing or the rate also clears the partial count in the prescaler.

Top module: `tmr_assignable_timer`

## Requirements
- R1: After a synchronous reset the configuration byte reads 0xFF, the control byte reads 0x00, and both `irq` and `wdt_tick` are low.
- R2: Configuration bit 5 selects the count source. When it is 1, edges on `ext_pin` are counted and `cyc_en` is ignored. When it is 0, `cyc_en` pulses are counted and `ext_pin` is ignored.
- R3: `ext_pin` passes through a two-stage synchronizer and then an edge detector. Configuration bit 4 = 0 counts low-to-high transitions and bit 4 = 1 counts high-to-low transitions. A single transition advances the timer (undivided) on the third rising clock edge after the pin changes.
- R4: When configuration bit 3 = 0, the prescaler belongs to the timer. The rate field in bits 2:0, with code k, gives one timer increment per 2^(k+1) source events.
- R5: When configuration bit 3 = 1, the prescaler divides `cyc_en` pulses by 2^k for rate code k. `wdt_tick` is then a one-cycle pulse one clock after each completed ratio, and the timer advances once per source event. When bit 3 = 0, `wdt_tick` stays low.
- R6: A wrap of the timer from 0xFF to 0x00 sets the overflow flag (control bit 0). The flag stays set until a control write puts it to 0. `irq` is high exactly when the flag and the enable (control bit 1) are both 1.
- R7: A write to the timer loads the written value on that clock edge and clears the prescaler. The timer then ignores count events until two `cyc_en` pulses have passed after the load.
- R8: A configuration write that changes bit 3 or bits 2:0 clears the prescaler's partial count. Counting then restarts from zero with the new ratio.
- R9: The register addresses are 0 for the timer, 1 for configuration (all 8 bits read back as written), 2 for control, and 3, which reads as zero. `rd_data` follows `rd_addr` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per instruction cycle |
| ext_pin | input | 1 | Asynchronous external clock input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Overflow interrupt request (flag AND enable) |
| wdt_tick | output | 1 | Divided tick for the watchdog path |

## Verification
The bench builds the block with its defaults: an 8-bit timer, a two-stage synchronizer and a two-cycle hold-off. With these values a wrap is reached within a few cycles of a preload, and every rate code, including the largest division of 256, completes within short windows. The three-edge pin latency and the two-cycle stall can both be checked on exact cycles. A behavioural model runs beside the design under sparse, dense and random `cyc_en` patterns and a toggling pin, and it is compared on every clock. It is supported by window counts of increments and watchdog ticks, and by cycle-exact probes around reloads and rate changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int RATE_W = 3;
    localparam int PS_W   = 1 << RATE_W;
    localparam int CFG_W  = 8;

    // Bit positions 5..0 are decoded by the timer logic; 7..6 are stored only.
    typedef struct packed {
        logic              spare_hi;
        logic              spare_lo;
        logic              src_ext;
        logic              edge_fall;
        logic              ps_to_wdt;
        logic [RATE_W-1:0] rate;
    } tmr_cfg_t;

    localparam tmr_cfg_t CFG_RESET = tmr_cfg_t'({CFG_W{1'b1}});

    typedef enum logic [1:0] {
        RA_TIMER = 2'd0,
        RA_CFG   = 2'd1,
        RA_CTRL  = 2'd2,
        RA_SPARE = 2'd3
    } tmr_addr_e;

    // Terminal count of the shared prescaler for a rate code and an owner.
    function automatic logic [PS_W-1:0] ps_last(input logic [RATE_W-1:0] rate,
                                                input logic to_wdt);
        int unsigned sh;
        logic [PS_W:0] span;
        sh   = int'(rate) + (to_wdt ? 0 : 1);
        span = {{PS_W{1'b0}}, 1'b1} << sh;
        return PS_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    logic rise, fall;
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
    assign evt  = fall_sel ? fall : rise;

    // R3: an edge of one polarity cannot be reported on two cycles in a row
    p_evt_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (evt && !fall_sel) |=> !(evt && !fall_sel));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_evt,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              hit
);
    logic [PS_W-1:0] cnt;
    logic [PS_W-1:0] last;

    assign last = ps_last(rate, to_wdt);
    assign hit  = in_evt & (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (in_evt) cnt <= hit ? '0 : cnt + 1'b1;
    end

    // R8: the partial count never exceeds the terminal value of the current ratio
    p_ps_range_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R8: a clear request leaves the count at zero
    p_ps_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W    = 8,
    parameter int HOLD = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cyc_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         ovf,
    output logic         holding
);
    localparam int HW = $clog2(HOLD + 1);

    logic [W-1:0]  val_q;
    logic [HW-1:0] hold_q;

    // The count value is deliberately left out of reset.
    always_ff @(posedge clk) begin
        if (load)     val_q <= load_val;
        else if (inc) val_q <= val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                    hold_q <= '0;
        else if (load)              hold_q <= HW'(HOLD);
        else if (holding && cyc_en) hold_q <= hold_q - 1'b1;
    end

    assign holding = (hold_q != '0);
    assign ovf     = inc & ~load & (&val_q);
    assign val     = val_q;

    // R7: a load appears on the following cycle
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> val == $past(load_val));

    // R7: no increment reaches the counter while the hold-off runs
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (holding && !load) |=> val == $past(val));

    // R4: without a load the value moves by at most one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> (val == $past(val)) || (val == W'($past(val) + 1'b1)));

    // R6: an overflow leaves the counter at zero
    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        ovf |=> val == '0);

endmodule

// File: rtl/tmr_assignable_timer.sv
module tmr_assignable_timer
    import tmr_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CFG_W-1:0] rd_data,
    output logic             irq,
    output logic             wdt_tick
);
    tmr_cfg_t   cfg_q;
    tmr_cfg_t   cfg_new;
    logic       flag_q, ie_q, wdt_q;
    logic       tmr_wr, cfg_wr, ctrl_wr, cfg_chg;
    logic       pin_evt, src_evt, ps_in, ps_clr, ps_hit, inc_req;
    logic       ovf, holding;
    logic [TMR_W-1:0] tmr_val;

    // register write decode
    assign tmr_wr  = wr_en && (tmr_addr_e'(wr_addr) == RA_TIMER);
    assign cfg_wr  = wr_en && (tmr_addr_e'(wr_addr) == RA_CFG);
    assign ctrl_wr = wr_en && (tmr_addr_e'(wr_addr) == RA_CTRL);
    assign cfg_new = tmr_cfg_t'(wr_data);
    assign cfg_chg = cfg_wr && ((cfg_new.ps_to_wdt != cfg_q.ps_to_wdt) ||
                                (cfg_new.rate != cfg_q.rate));

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= cfg_new;
    end

    // count source and prescaler routing
    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .fall_sel(cfg_q.edge_fall), .evt(pin_evt)
    );

    assign src_evt = cfg_q.src_ext ? pin_evt : cyc_en;
    assign ps_in   = cfg_q.ps_to_wdt ? cyc_en : (src_evt & ~holding);
    assign ps_clr  = tmr_wr | cfg_chg;
    assign inc_req = cfg_q.ps_to_wdt ? (src_evt & ~holding) : ps_hit;

    tmr_prescaler u_ps (
        .clk(clk), .rst(rst), .clr(ps_clr), .in_evt(ps_in),
        .to_wdt(cfg_q.ps_to_wdt), .rate(cfg_q.rate), .hit(ps_hit)
    );

    tmr_counter #(.W(TMR_W), .HOLD(HOLD_CYC)) u_cnt (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .load(tmr_wr),
        .load_val(TMR_W'(wr_data)), .inc(inc_req),
        .val(tmr_val), .ovf(ovf), .holding(holding)
    );

    // flag, enable and watchdog tick
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            wdt_q  <= 1'b0;
        end else begin
            wdt_q <= cfg_q.ps_to_wdt & ps_hit;
            if (ctrl_wr) begin
                flag_q <= wr_data[0] | ovf;
                ie_q   <= wr_data[1];
            end else if (ovf) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign irq      = flag_q & ie_q;
    assign wdt_tick = wdt_q;

    always_comb begin
        case (tmr_addr_e'(rd_addr))
            RA_TIMER: rd_data = CFG_W'(tmr_val);
            RA_CFG:   rd_data = cfg_q;
            RA_CTRL:  rd_data = {{(CFG_W-2){1'b0}}, ie_q, flag_q};
            default:  rd_data = '0;
        endcase
    end

    // R1: configuration holds its reset value right after reset
    p_cfg_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_q == CFG_RESET);

    // R6: an overflow always leaves the flag set
    p_ovf_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag_q);

    // R6: only a control write can drop the flag
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ctrl_wr) |=> flag_q);

    // R5: watchdog ticks come only from a watchdog-owned prescaler
    p_wdt_owner_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_tick |-> $past(cfg_q.ps_to_wdt));

    // R2: with the internal source and no cycle pulse the timer stands still
    p_src_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!tmr_wr && !cfg_q.src_ext && !cyc_en) |=> tmr_val == $past(tmr_val));

endmodule

// File: tb/tb_tmr_assignable_timer.sv
module tb_tmr_assignable_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd1;
    logic [7:0] rd_data;
    logic       irq, wdt_tick;

    always #10 clk = ~clk;

    tmr_assignable_timer dut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wdt_tick(wdt_tick)
    );

    int    total = 0;
    int    bad   = 0;
    string phase = "R1";

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // stimulus for cyc_en and the pin
    int cyc_mode = 0;   // 0 none, 1 every cycle, 2 sparse random, 3 dense random
    int pin_per  = 0;   // 0 = hold pin_lvl, else toggle every pin_per cycles
    int pin_lvl  = 0;
    int pin_cnt  = 0;

    always @(negedge clk) begin
        case (cyc_mode)
            0:       cyc_en = 1'b0;
            1:       cyc_en = 1'b1;
            2:       cyc_en = ($urandom_range(0, 3) == 0);
            default: cyc_en = ($urandom_range(0, 1) == 1);
        endcase
        if (pin_per == 0) begin
            ext_pin = (pin_lvl != 0);
        end else begin
            pin_cnt++;
            if (pin_cnt >= pin_per) begin
                pin_cnt = 0;
                ext_pin = ~ext_pin;
            end
        end
    end

    // behavioural reference model
    int m_cfg, m_flag, m_ie, m_tmr, m_known, m_pcnt, m_hold, m_wdt;
    int s1, s2, s3;
    initial begin
        m_known = 0;
        m_tmr   = 0;
    end

    always @(posedge clk) begin : model
        int ext, src, asg, rate, held, pre_in, last, hit, tev, ovf;
        int twr, cwr, kwr;
        if (rst) begin
            m_cfg = 255; m_flag = 0; m_ie = 0; m_pcnt = 0; m_hold = 0; m_wdt = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            twr  = (wr_en && wr_addr == 2'd0) ? 1 : 0;
            cwr  = (wr_en && wr_addr == 2'd1) ? 1 : 0;
            kwr  = (wr_en && wr_addr == 2'd2) ? 1 : 0;
            if (m_cfg[4]) ext = (s2 == 0 && s3 == 1) ? 1 : 0;
            else          ext = (s2 == 1 && s3 == 0) ? 1 : 0;
            src  = m_cfg[5] ? ext : int'(cyc_en);
            asg  = m_cfg[3];
            rate = m_cfg & 7;
            held = (m_hold > 0) ? 1 : 0;
            if (asg) begin
                pre_in = int'(cyc_en);
                last   = (1 << rate) - 1;
            end else begin
                pre_in = (src && !held) ? 1 : 0;
                last   = (1 << (rate + 1)) - 1;
            end
            hit = (pre_in && m_pcnt == last) ? 1 : 0;
            tev = asg ? ((src && !held) ? 1 : 0) : hit;
            ovf = (!twr && tev && m_tmr == 255) ? 1 : 0;
            m_wdt = asg && hit;
            if (twr || (cwr && ((int'(wr_data) & 15) != (m_cfg & 15)))) m_pcnt = 0;
            else if (pre_in) m_pcnt = hit ? 0 : m_pcnt + 1;
            if (twr) begin
                m_tmr = wr_data; m_hold = 2; m_known = 1;
            end else begin
                if (tev) m_tmr = (m_tmr + 1) & 255;
                if (m_hold > 0 && cyc_en) m_hold--;
            end
            if (kwr) begin
                m_flag = wr_data[0] | ovf;
                m_ie   = wr_data[1];
            end else if (ovf) begin
                m_flag = 1;
            end
            if (cwr) m_cfg = wr_data;
            s3 = s2; s2 = s1; s1 = int'(ext_pin);
        end
    end

    // compare with the model on every clock, away from the edge
    always @(posedge clk) begin
        #5;
        if (!rst) begin
            check({phase, " irq"}, int'(irq), m_flag & m_ie);
            check({phase, " wdt_tick"}, int'(wdt_tick), m_wdt);
            case (rd_addr)
                2'd0: if (m_known) check({phase, " timer"}, int'(rd_data), m_tmr);
                2'd1: check({phase, " cfg"}, int'(rd_data), m_cfg);
                2'd2: check({phase, " ctrl"}, int'(rd_data), m_ie * 2 + m_flag);
                default: check({phase, " spare"}, int'(rd_data), 0);
            endcase
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        @(posedge clk);
        #5;
        v = int'(rd_data);
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_addr = rd_addr + 2'd1;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, v0, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(posedge clk); #5;
        check("R1 cfg", int'(rd_data), 8'hFF);
        check("R1 irq", int'(irq), 0);
        check("R1 wdt_tick", int'(wdt_tick), 0);
        peek(2'd2, v);
        check("R1 ctrl", v, 0);

        // R9 register map
        phase = "R9";
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hC0);
        peek(2'd1, v);
        check("R9 cfg readback", v, 8'hC0);
        peek(2'd3, v);
        check("R9 spare", v, 0);

        // R7 reload with hold-off: timer-owned, divide by 2, cyc every cycle
        phase = "R7";
        cyc_mode = 1;
        wr(2'd1, 8'h00);
        run(5);
        @(negedge clk);
        rd_addr = 2'd0;
        wr(2'd0, 8'h37);
        @(posedge clk); #5; check("R7 hold 1", int'(rd_data), 8'h37);
        @(posedge clk); #5; check("R7 hold 2", int'(rd_data), 8'h37);
        @(posedge clk); #5; check("R7 prescale", int'(rd_data), 8'h37);
        @(posedge clk); #5; check("R7 first inc", int'(rd_data), 8'h38);

        // R6 overflow flag and interrupt
        phase = "R6";
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h08);
        @(negedge clk);
        rd_addr = 2'd2;
        wr(2'd0, 8'hFE);
        repeat (4) @(posedge clk);
        #5;
        check("R6 flag on wrap", int'(rd_data), 3);
        check("R6 irq", int'(irq), 1);
        run(20);
        peek(2'd2, v);
        check("R6 sticky", v, 3);
        wr(2'd2, 8'h02);
        peek(2'd2, v);
        check("R6 cleared", v, 2);
        check("R6 irq low", int'(irq), 0);

        // R5 watchdog ownership
        phase = "R5";
        wr(2'd1, 8'h0A);
        run(6);
        n = 0;
        repeat (40) begin
            @(posedge clk); #5;
            n += int'(wdt_tick);
        end
        check("R5 tick count div4", n, 10);
        peek(2'd0, v0);
        repeat (40) @(posedge clk);
        #5;
        check("R5 timer undivided", int'(rd_data), (v0 + 40) & 255);
        cyc_mode = 3;
        run(200);

        // R4 timer-owned division
        phase = "R4";
        cyc_mode = 1;
        wr(2'd1, 8'h02);
        run(6);
        n = 0;
        repeat (40) begin
            @(posedge clk); #5;
            n += int'(wdt_tick);
        end
        check("R5 no tick when timer owns", n, 0);
        peek(2'd0, v0);
        repeat (80) @(posedge clk);
        #5;
        check("R4 div8 window", int'(rd_data), (v0 + 10) & 255);
        wr(2'd1, 8'h07);
        cyc_mode = 2;
        run(1200);
        cyc_mode = 1;
        wr(2'd1, 8'h00);
        run(40);

        // R2 source select
        phase = "R2";
        cyc_mode = 2;
        wr(2'd1, 8'h28);
        run(6);
        peek(2'd0, v0);
        repeat (40) @(posedge clk);
        #5;
        check("R2 cyc ignored on pin source", int'(rd_data), v0);
        pin_per = 4;
        run(10);
        peek(2'd0, v0);
        repeat (80) @(posedge clk);
        #5;
        check("R2 pin edges counted", int'(rd_data), (v0 + 10) & 255);
        cyc_mode = 1;
        wr(2'd1, 8'h08);
        run(6);
        peek(2'd0, v0);
        repeat (40) @(posedge clk);
        #5;
        check("R2 pin ignored on cycle source", int'(rd_data), (v0 + 40) & 255);
        wr(2'd1, 8'h21);
        run(300);

        // R3 edge polarity
        phase = "R3";
        pin_per = 0;
        pin_lvl = 0;
        wr(2'd1, 8'h28);
        run(8);
        peek(2'd0, v0);
        pin_lvl = 1;
        run(6);
        peek(2'd0, v);
        check("R3 rising counted", v, (v0 + 1) & 255);
        wr(2'd1, 8'h38);
        pin_lvl = 0;
        run(6);
        peek(2'd0, v);
        check("R3 falling counted", v, (v0 + 2) & 255);
        pin_lvl = 1;
        run(6);
        peek(2'd0, v);
        check("R3 rising ignored", v, (v0 + 2) & 255);

        // R8 rate change clears the partial count
        phase = "R8";
        cyc_mode = 1;
        wr(2'd1, 8'h06);
        run(50);
        @(negedge clk);
        rd_addr = 2'd0;
        wr(2'd1, 8'h00);
        @(posedge clk); #5;
        v = int'(rd_data);
        @(posedge clk); #5;
        check("R8 restart after rate change", int'(rd_data), (v + 1) & 255);
        cyc_mode = 3;
        wr(2'd1, 8'h8B);
        run(300);

        finish_run();
    end

endmodule